// File: doc/BRIEF.md
# Mode-Banked Processor Register File

This block is the architectural register store of a 32-bit processor that runs in several operating modes. Sixteen logical registers are addressed by a 4-bit index. Depending on the current mode, some of those indices point at private copies of a register instead of the shared ones. The store holds 31 general 32-bit registers and 6 status words: one current status register and one saved status register for each of the five exception modes.

There are two combinational read ports and one synchronous write port, and all three use the current mode. A second write port takes its own mode value. Exception entry uses it to place the return address in the new mode's link register while the current mode input still shows the old mode. The current status word and the saved status word each have a read port and a write port.

A narrow-instruction flag limits the view to R0 to R7, SP (R13), LR (R14) and PC (R15). SP and LR keep the same mode-dependent banking in this view. Decode, ALU, exception sequencing and PC increment are outside the block.

Top module: `banked_regfile`

## Requirements
- R1: After reset, every register, the current status word and every saved status word read as zero.
- R2: Indices 0 to 7 and index 15 map to one shared copy each, whatever the mode.
- R3: In the mode encoded 10001, indices 8 to 14 map to a private set of seven registers. In every other mode, indices 8 to 12 map to the shared copies.
- R4: The modes encoded 10010, 10011, 10111 and 11011 each have their own private copies of indices 13 and 14 only. These copies are distinct from each other, from the shared copies and from the set in R3.
- R5: Mode 10000 and mode 11111 use the same physical registers. Any mode value not listed in R3 or R4 behaves as 10000.
- R6: Each of the five exception modes (10001, 10010, 10011, 10111, 11011) has its own saved status word. A saved-status write in such a mode is readable in that same mode from the next cycle.
- R7: In mode 10000 or 11111, a saved-status write changes no saved status word, and the saved-status read port returns the current status word.
- R8: When a read port and the write port address the same register in one cycle, the read returns the old value. The new value is read from the following cycle.
- R9: The second write port writes into the bank chosen by its own mode input and ignores the current mode. If both write ports hit the same physical register in one cycle, the second port's data is kept.
- R10: While the narrow flag is 1, reads of indices 8 to 12 return zero and main-port writes to indices 8 to 12 are dropped. Indices 13 and 14 stay banked as in R3 and R4.
- R11: A current-status write is readable on the current-status port from the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode | input | 5 | Current operating mode |
| narrow | input | 1 | Narrow-instruction view enable |
| rd_a_idx | input | 4 | Read port A index |
| rd_a_data | output | W | Read port A data |
| rd_b_idx | input | 4 | Read port B index |
| rd_b_data | output | W | Read port B data |
| wr_en | input | 1 | Main write enable |
| wr_idx | input | 4 | Main write index |
| wr_data | input | W | Main write data |
| alt_wr_en | input | 1 | Mode-explicit write enable |
| alt_mode | input | 5 | Mode used by the mode-explicit write |
| alt_idx | input | 4 | Mode-explicit write index |
| alt_data | input | W | Mode-explicit write data |
| status_wr_en | input | 1 | Current status write enable |
| status_wr_data | input | W | Current status write data |
| status_rd | output | W | Current status word |
| saved_wr_en | input | 1 | Saved status write enable |
| saved_wr_data | input | W | Saved status write data |
| saved_rd | output | W | Saved status word of the current mode |

## Verification
The hardest state to reach is one where every bank holds a different value at the same index. Only then does a wrong bank selection show up as a wrong read. The stimulus therefore first fills the shared registers and every private copy with values that encode both the mode and the index. It then reads each index across the modes.

The mode-explicit port has to be driven while the current mode input is deliberately set to another mode. That is the only way to show it ignores the current mode. It is also driven in the same cycle as a main-port write to the same register, to expose the collision priority.

// File: rtl/banked_regfile.sv
module banked_regfile #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [4:0]   mode,
  input  logic         narrow,
  input  logic [3:0]   rd_a_idx,
  output logic [W-1:0] rd_a_data,
  input  logic [3:0]   rd_b_idx,
  output logic [W-1:0] rd_b_data,
  input  logic         wr_en,
  input  logic [3:0]   wr_idx,
  input  logic [W-1:0] wr_data,
  input  logic         alt_wr_en,
  input  logic [4:0]   alt_mode,
  input  logic [3:0]   alt_idx,
  input  logic [W-1:0] alt_data,
  input  logic         status_wr_en,
  input  logic [W-1:0] status_wr_data,
  output logic [W-1:0] status_rd,
  input  logic         saved_wr_en,
  input  logic [W-1:0] saved_wr_data,
  output logic [W-1:0] saved_rd
);
  localparam int NPHYS  = 31;
  localparam int NSAVED = 5;

  logic [W-1:0] gpr   [NPHYS];
  logic [W-1:0] spsr  [NSAVED];
  logic [W-1:0] cpsr;

  // bank code: 0 shared, 1 fast-irq, 2 irq, 3 svc, 4 abort, 5 undef
  function automatic logic [2:0] bank_of(input logic [4:0] m);
    case (m)
      5'b10001: return 3'd1;
      5'b10010: return 3'd2;
      5'b10011: return 3'd3;
      5'b10111: return 3'd4;
      5'b11011: return 3'd5;
      default:  return 3'd0;
    endcase
  endfunction

  function automatic logic [4:0] phys(input logic [2:0] b, input logic [3:0] i);
    if (b == 3'd1 && i >= 4'd8 && i <= 4'd14)
      return 5'(i) + 5'd8;
    else if (b >= 3'd2 && (i == 4'd13 || i == 4'd14))
      return 5'd23 + 5'({b - 3'd2, 1'b0}) + 5'(i == 4'd14);
    else
      return 5'(i);
  endfunction

  function automatic logic hidden(input logic n, input logic [3:0] i);
    return n && i >= 4'd8 && i <= 4'd12;
  endfunction

  logic [2:0] cur_bank, alt_bank, sidx;
  logic [4:0] pa, pb, pw, palt;

  assign cur_bank = bank_of(mode);
  assign alt_bank = bank_of(alt_mode);
  assign sidx     = cur_bank - 3'd1;
  assign pa       = phys(cur_bank, rd_a_idx);
  assign pb       = phys(cur_bank, rd_b_idx);
  assign pw       = phys(cur_bank, wr_idx);
  assign palt     = phys(alt_bank, alt_idx);

  assign rd_a_data = hidden(narrow, rd_a_idx) ? '0 : gpr[pa];
  assign rd_b_data = hidden(narrow, rd_b_idx) ? '0 : gpr[pb];
  assign status_rd = cpsr;
  assign saved_rd  = (cur_bank == 3'd0) ? cpsr : spsr[sidx];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int k = 0; k < NPHYS; k++) gpr[k] <= '0;
      for (int k = 0; k < NSAVED; k++) spsr[k] <= '0;
      cpsr <= '0;
    end else begin
      if (wr_en && !hidden(narrow, wr_idx)) gpr[pw] <= wr_data;
      if (alt_wr_en) gpr[palt] <= alt_data;
      if (status_wr_en) cpsr <= status_wr_data;
      if (saved_wr_en && cur_bank != 3'd0) spsr[sidx] <= saved_wr_data;
    end
  end
endmodule

// File: rtl/banked_regfile_chk.sv
module banked_regfile_chk #(
  parameter int W = 32
) (
  input logic         clk,
  input logic         rst_n,
  input logic [4:0]   mode,
  input logic         narrow,
  input logic [3:0]   rd_a_idx,
  input logic [W-1:0] rd_a_data,
  input logic         wr_en,
  input logic [3:0]   wr_idx,
  input logic [W-1:0] wr_data,
  input logic         alt_wr_en,
  input logic         status_wr_en,
  input logic [W-1:0] status_wr_data,
  input logic [W-1:0] status_rd,
  input logic [W-1:0] saved_rd
);
  // R8
  write_visible_next_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(wr_en) && !$past(alt_wr_en) && !narrow && !$past(narrow)
     && rd_a_idx == $past(wr_idx) && mode == $past(mode))
    |-> rd_a_data == $past(wr_data));

  // R7
  saved_mirrors_status_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 5'b10000 || mode == 5'b11111) |-> saved_rd == status_rd);

  // R10
  narrow_hides_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (narrow && rd_a_idx >= 4'd8 && rd_a_idx <= 4'd12) |-> rd_a_data == '0);

  // R11
  status_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(status_wr_en)) |-> status_rd == $past(status_wr_data));
endmodule

bind banked_regfile banked_regfile_chk #(.W(W)) chk_i (.*);

// File: tb/banked_regfile_test.sv
`timescale 1ns/1ps
module banked_regfile_test;
  localparam logic [4:0] USR = 5'b10000, FIQ = 5'b10001, IRQ = 5'b10010,
                         SVC = 5'b10011, ABT = 5'b10111, UND = 5'b11011,
                         SYS = 5'b11111;

  logic clk = 0, rst_n = 0;
  logic [4:0] mode = USR, alt_mode = USR;
  logic narrow = 0, wr_en = 0, alt_wr_en = 0, status_wr_en = 0, saved_wr_en = 0;
  logic [3:0] rd_a_idx = 0, rd_b_idx = 0, wr_idx = 0, alt_idx = 0;
  logic [31:0] wr_data = 0, alt_data = 0, status_wr_data = 0, saved_wr_data = 0;
  logic [31:0] rd_a_data, rd_b_data, status_rd, saved_rd;

  always #10 clk = ~clk;

  banked_regfile uut (.*);

  typedef struct { int kind; logic [31:0] exp; string tag; } item_t;
  item_t sbq[$];
  event sample_ev;
  int total = 0, bad = 0;
  bit done = 0;

  initial forever begin
    @(sample_ev);
    while (sbq.size() > 0) begin
      item_t it;
      logic [31:0] act;
      it = sbq.pop_front();
      case (it.kind)
        0: act = rd_a_data;
        1: act = rd_b_data;
        2: act = saved_rd;
        default: act = status_rd;
      endcase
      total++;
      if (act !== it.exp) begin
        bad++;
        $display("FAIL %s: got %h expected %h", it.tag, act, it.exp);
      end
    end
  end

  task automatic push(int kind, logic [31:0] exp, string tag);
    item_t it;
    it.kind = kind; it.exp = exp; it.tag = tag;
    sbq.push_back(it);
    #1 -> sample_ev;
    #1;
  endtask

  task automatic wr(logic [4:0] m, logic [3:0] i, logic [31:0] d);
    @(negedge clk);
    mode = m; wr_idx = i; wr_data = d; wr_en = 1;
    @(posedge clk); #1 wr_en = 0;
  endtask

  task automatic rd(logic [4:0] m, logic [3:0] i, logic [31:0] e, string tag);
    @(negedge clk);
    mode = m; rd_a_idx = i; rd_b_idx = i;
    push(0, e, tag);
    push(1, e, tag);
  endtask

  task automatic saved_wr(logic [4:0] m, logic [31:0] d);
    @(negedge clk);
    mode = m; saved_wr_data = d; saved_wr_en = 1;
    @(posedge clk); #1 saved_wr_en = 0;
  endtask

  task automatic saved_chk(logic [4:0] m, logic [31:0] e, string tag);
    @(negedge clk);
    mode = m;
    push(2, e, tag);
  endtask

  initial begin
    #(200000 * 20);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;

    // R1 reset state
    rd(USR, 4'd0, 32'h0, "R1 r0");
    rd(FIQ, 4'd9, 32'h0, "R1 fiq r9");
    push(3, 32'h0, "R1 status");
    saved_chk(SVC, 32'h0, "R1 saved");

    for (int i = 0; i < 16; i++) wr(USR, 4'(i), 32'h1000 + i);
    for (int i = 8; i < 15; i++) wr(FIQ, 4'(i), 32'hF000 + i);
    for (int i = 13; i < 15; i++) begin
      wr(IRQ, 4'(i), 32'h2000 + i);
      wr(SVC, 4'(i), 32'h3000 + i);
      wr(ABT, 4'(i), 32'h4000 + i);
      wr(UND, 4'(i), 32'h5000 + i);
    end

    // R2 shared registers
    rd(FIQ, 4'd3, 32'h1003, "R2 fiq r3");
    rd(UND, 4'd15, 32'h100F, "R2 und pc");
    rd(IRQ, 4'd7, 32'h1007, "R2 irq r7");
    // R3 fast-irq bank
    rd(FIQ, 4'd8, 32'hF008, "R3 fiq r8");
    rd(FIQ, 4'd14, 32'hF00E, "R3 fiq r14");
    rd(USR, 4'd8, 32'h1008, "R3 usr r8");
    // R4 two-register banks
    rd(IRQ, 4'd13, 32'h200D, "R4 irq sp");
    rd(SVC, 4'd14, 32'h300E, "R4 svc lr");
    rd(ABT, 4'd13, 32'h400D, "R4 abt sp");
    rd(UND, 4'd14, 32'h500E, "R4 und lr");
    rd(IRQ, 4'd10, 32'h100A, "R4 irq r10 shared");
    rd(USR, 4'd13, 32'h100D, "R4 usr sp");
    // R5 system and unlisted encodings
    rd(SYS, 4'd13, 32'h100D, "R5 sys sp");
    rd(5'b00000, 4'd14, 32'h100E, "R5 bad mode lr");
    wr(SYS, 4'd9, 32'hAAAA);
    rd(USR, 4'd9, 32'hAAAA, "R5 sys write seen in usr");

    // R11 current status
    @(negedge clk);
    status_wr_data = 32'hC0DE; status_wr_en = 1;
    @(posedge clk); #1 status_wr_en = 0;
    push(3, 32'hC0DE, "R11 status");

    // R6 saved status words
    saved_wr(FIQ, 32'h51);
    saved_wr(IRQ, 32'h52);
    saved_wr(SVC, 32'h53);
    saved_wr(ABT, 32'h57);
    saved_wr(UND, 32'h5B);
    saved_chk(FIQ, 32'h51, "R6 fiq");
    saved_chk(IRQ, 32'h52, "R6 irq");
    saved_chk(SVC, 32'h53, "R6 svc");
    saved_chk(ABT, 32'h57, "R6 abt");
    saved_chk(UND, 32'h5B, "R6 und");

    // R7 no saved word in user/system
    saved_wr(USR, 32'hBAD);
    saved_wr(SYS, 32'hBAD);
    saved_chk(USR, 32'hC0DE, "R7 usr reads status");
    saved_chk(SYS, 32'hC0DE, "R7 sys reads status");
    saved_chk(SVC, 32'h53, "R7 svc untouched");
    saved_chk(FIQ, 32'h51, "R7 fiq untouched");

    // R8 read during write
    @(negedge clk);
    mode = USR; rd_a_idx = 4'd4; wr_idx = 4'd4; wr_data = 32'h4444; wr_en = 1;
    push(0, 32'h1004, "R8 old value");
    @(posedge clk); #1 wr_en = 0;
    push(0, 32'h4444, "R8 new value");

    // R9 mode-explicit port
    @(negedge clk);
    mode = USR; alt_mode = IRQ; alt_idx = 4'd14; alt_data = 32'h9999; alt_wr_en = 1;
    @(posedge clk); #1 alt_wr_en = 0;
    rd(IRQ, 4'd14, 32'h9999, "R9 irq lr via alt");
    rd(USR, 4'd14, 32'h100E, "R9 usr lr untouched");
    @(negedge clk);
    mode = USR; wr_idx = 4'd2; wr_data = 32'h1; wr_en = 1;
    alt_mode = SYS; alt_idx = 4'd2; alt_data = 32'h2; alt_wr_en = 1;
    @(posedge clk); #1 begin wr_en = 0; alt_wr_en = 0; end
    rd(USR, 4'd2, 32'h2, "R9 collision alt wins");

    // R10 narrow view
    narrow = 1;
    rd(USR, 4'd9, 32'h0, "R10 r9 hidden");
    wr(USR, 4'd10, 32'h7777);
    rd(SVC, 4'd13, 32'h300D, "R10 svc sp banked");
    rd(FIQ, 4'd14, 32'hF00E, "R10 fiq lr banked");
    narrow = 0;
    rd(USR, 4'd10, 32'h100A, "R10 write dropped");

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule